// File: doc/BRIEF.md
# Absolute Indexed Operand Fetch Sequencer

This block is the per-cycle control and datapath of one instruction class in a small 8-bit processor with a 16-bit address space. The instruction class reads a single operand from an absolute address plus an index. The sequencer reads an opcode byte and then a two-byte base address, least significant byte first, from the program stream. It adds an 8-bit index register to the base and reads the operand from the resulting address. It then either loads the operand into the accumulator or ORs the operand into the accumulator.

A single 8-bit adder forms the operand address. The low byte is summed while the high byte is being fetched. The carry out of that sum is held in a private latch. The sequencer uses that carry to choose its path. With no carry, the operand is read in the fourth cycle. With a carry, the sequencer inserts one extra cycle in which the same adder increments the high byte, and the operand is read in the fifth cycle.

The accumulator and status register are held outside the block. The block receives their current values and returns new values, with a write strobe that is raised during the fetch of the next opcode. Memory read data is combinational: a byte is valid during the same cycle its address is driven, and it is captured at the end of that cycle.

Top module: `idx_abs_seq`

## Requirements
- R1: After an opcode fetch, the next two cycles are operand fetches. The three addresses are consecutive program-counter values. The first operand byte is the base low byte and the second is the base high byte.
- R2: When base low byte plus index is at most 0xFF, the cycle after the high-byte fetch is a data read at {base high, low sum}. The next opcode fetch follows at once, giving 4 cycles per instruction.
- R3: When base low byte plus index exceeds 0xFF, the cycle after the high-byte fetch is a dummy cycle addressed {base high, low sum}. It is followed by a data read at {base high + 1, low sum}, giving 5 cycles per instruction.
- R4: The index is zero-extended and the operand address wraps modulo 2^16. For example, base 0xFFFF with index 0x01 reads address 0x0000.
- R5: For any opcode byte other than the OR code, the operand byte appears on `acc_o` with `acc_we` high during the opcode fetch cycle that follows the data read.
- R6: For opcode byte 0x1D, `acc_o` is `acc_i` OR the operand, written in the same cycle as in R5.
- R7: On write-back, `psr_o` bit 1 is set exactly when the result is 0x00, and bit 7 equals result bit 7. All other bits, including the carry bit 0, equal `psr_i` from the data-read cycle.
- R8: `bus_kind` encodes the cycle type: 0 = opcode fetch, 1 = operand fetch, 2 = dummy cycle, 3 = data read.
- R9: While `rst_n` is low at a clock edge, the sequencer enters the opcode fetch state at address 0x0200, drops `acc_we` and clears the address-carry latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 16 | Read address for the current cycle |
| mem_rdata | input | 8 | Read data for the address driven in this cycle |
| bus_kind | output | 2 | Cycle type code (R8) |
| idx | input | 8 | Index register value |
| acc_i | input | 8 | Current accumulator |
| psr_i | input | 8 | Current status register |
| acc_we | output | 1 | Accumulator and status write strobe |
| acc_o | output | 8 | New accumulator value |
| psr_o | output | 8 | New status register value |

## Verification
The assertions assume that read data is valid in the same cycle as its address. They also assume that `idx` is stable during the high-byte fetch and that `acc_i` and `psr_i` are stable during the data read. The bench meets these assumptions by driving memory data combinationally from a function of `mem_addr`. It changes the index, accumulator and status inputs only at the falling edge that opens a new instruction's opcode fetch, and holds them for the whole instruction. The stimulus is chosen to cover both the carry and no-carry paths, the wrap past 0xFFFF, a zero result and a negative result.

// File: rtl/idx_abs_seq_pkg.sv
// Shared types for the absolute indexed operand fetch sequencer.
// Assumes bus_kind codes are decoded by neighbouring logic, so values are fixed.
package idx_abs_seq_pkg;

    typedef enum logic [1:0] {
        BK_OPC   = 2'd0,
        BK_OPR   = 2'd1,
        BK_DUMMY = 2'd2,
        BK_DATA  = 2'd3
    } bus_kind_t;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_LO,
        ST_HI,
        ST_FIX,
        ST_RD
    } seq_state_t;

    localparam int ZERO_BIT = 1;
    localparam int NEG_BIT  = 7;

endpackage

// File: rtl/idx_abs_add.sv
// Byte-wide adder shared by the low-byte sum and the high-byte increment.
// Assumes nothing; purely combinational.
module idx_abs_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    // add with carry in, expose carry out
    always_comb begin
        {cout, sum} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end

endmodule

// File: rtl/idx_abs_fsm.sv
// Cycle sequencer: opcode, low byte, high byte, optional fix-up, data read.
// Assumes page_cy is the carry of the low-byte sum formed during ST_HI.
module idx_abs_fsm
    import idx_abs_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       page_cy,
    output seq_state_t state
);

    seq_state_t nxt;

    // next-state choice; carry picks the 5-cycle path
    always_comb begin
        case (state)
            ST_OPC:  nxt = ST_LO;
            ST_LO:   nxt = ST_HI;
            ST_HI:   nxt = page_cy ? ST_FIX : ST_RD;
            ST_FIX:  nxt = ST_RD;
            ST_RD:   nxt = ST_OPC;
            default: nxt = ST_OPC;
        endcase
    end

    // state register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OPC;
        else        state <= nxt;
    end

endmodule

// File: rtl/idx_abs_alu.sv
// Result and flag generation for load and OR variants.
// Assumes flags other than zero and negative pass through untouched.
module idx_abs_alu
    import idx_abs_seq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         is_or,
    input  logic [W-1:0] acc,
    input  logic [W-1:0] data,
    input  logic [7:0]   psr,
    output logic [W-1:0] res,
    output logic [7:0]   psr_new
);

    // select result then patch zero and negative bits
    always_comb begin
        res = is_or ? (acc | data) : data;
        psr_new = psr;
        psr_new[ZERO_BIT] = (res == '0);
        psr_new[NEG_BIT]  = res[W-1];
    end

endmodule

// File: rtl/idx_abs_seq.sv
// Absolute indexed read sequencer: builds base+index with one byte adder,
// adding a cycle only when the low sum carries. Assumes combinational read
// data, idx stable in the high-byte cycle, acc_i/psr_i stable in data read.
module idx_abs_seq
    import idx_abs_seq_pkg::*;
#(
    parameter int             DW       = 8,
    parameter int             AW       = 16,
    parameter logic [AW-1:0]  RESET_PC = 16'h0200,
    parameter logic [DW-1:0]  OPC_OR   = 8'h1D
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [1:0]    bus_kind,
    input  logic [DW-1:0] idx,
    input  logic [DW-1:0] acc_i,
    input  logic [7:0]    psr_i,
    output logic          acc_we,
    output logic [DW-1:0] acc_o,
    output logic [7:0]    psr_o
);

    localparam int HW = AW - DW;

    seq_state_t    state;
    logic [AW-1:0] pc;
    logic          opc_or;
    logic [DW-1:0] base_lo;
    logic [HW-1:0] base_hi;
    logic [DW-1:0] addr_lo;
    logic          cy_latch;
    logic [DW-1:0] add_a, add_b, add_sum;
    logic          add_cin, add_cout;
    logic [DW-1:0] alu_res;
    logic [7:0]    alu_psr;

    idx_abs_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .page_cy (add_cout),
        .state   (state)
    );

    idx_abs_add #(.W(DW)) u_add (
        .a    (add_a),
        .b    (add_b),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout)
    );

    idx_abs_alu #(.W(DW)) u_alu (
        .is_or   (opc_or),
        .acc     (acc_i),
        .data    (mem_rdata),
        .psr     (psr_i),
        .res     (alu_res),
        .psr_new (alu_psr)
    );

    // adder operand steering: low sum in ST_HI, high increment in ST_FIX
    always_comb begin
        add_a   = '0;
        add_b   = '0;
        add_cin = 1'b0;
        if (state == ST_HI) begin
            add_a = base_lo;
            add_b = idx;
        end else if (state == ST_FIX) begin
            add_a   = base_hi;
            add_cin = cy_latch;
        end
    end

    // address and cycle-type output per state
    always_comb begin
        case (state)
            ST_OPC: begin mem_addr = pc;                bus_kind = BK_OPC;   end
            ST_LO,
            ST_HI:  begin mem_addr = pc;                bus_kind = BK_OPR;   end
            ST_FIX: begin mem_addr = {base_hi, addr_lo}; bus_kind = BK_DUMMY; end
            default: begin mem_addr = {base_hi, addr_lo}; bus_kind = BK_DATA; end
        endcase
    end

    // program counter advances on every program-stream byte
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= RESET_PC;
        else if (state == ST_OPC || state == ST_LO || state == ST_HI) pc <= pc + 1'b1;
    end

    // capture opcode variant and base bytes, update high byte on fix-up
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opc_or  <= 1'b0;
            base_lo <= '0;
            base_hi <= '0;
        end else begin
            if (state == ST_OPC) opc_or  <= (mem_rdata == OPC_OR);
            if (state == ST_LO)  base_lo <= mem_rdata;
            if (state == ST_HI)  base_hi <= mem_rdata;
            if (state == ST_FIX) base_hi <= add_sum;
        end
    end

    // low address byte and private address-carry latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo  <= '0;
            cy_latch <= 1'b0;
        end else if (state == ST_HI) begin
            addr_lo  <= add_sum;
            cy_latch <= add_cout;
        end
    end

    // write-back registered so it overlaps the next opcode fetch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_we <= 1'b0;
            acc_o  <= '0;
            psr_o  <= '0;
        end else begin
            acc_we <= (state == ST_RD);
            if (state == ST_RD) begin
                acc_o <= alu_res;
                psr_o <= alu_psr;
            end
        end
    end

endmodule

// File: rtl/idx_abs_seq_chk.sv
// Property checker for idx_abs_seq, attached by bind below.
// Assumes the same input conditions as the design.
module idx_abs_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] mem_addr,
    input logic [1:0]  bus_kind,
    input logic        acc_we,
    input logic [7:0]  acc_o,
    input logic [7:0]  psr_o,
    input logic [7:0]  psr_i
);

    AST_OPR_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_kind == 2'd1) |-> ($past(bus_kind) == 2'd0 || $past(bus_kind) == 2'd1)); // R1

    AST_OPR_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_kind == 2'd1) |-> (mem_addr == $past(mem_addr) + 16'd1)); // R1

    AST_DUMMY_AFTER_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_kind == 2'd2) |-> ($past(bus_kind) == 2'd1)); // R3

    AST_HI_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_kind) == 2'd2 && bus_kind == 2'd3) |->
        (mem_addr == {$past(mem_addr[15:8]) + 8'd1, $past(mem_addr[7:0])})); // R3

    AST_DATA_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_kind == 2'd3) |=> (bus_kind == 2'd0 && acc_we)); // R5

    AST_ZN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |-> (psr_o[1] == (acc_o == 8'h00) && psr_o[7] == acc_o[7])); // R7

    AST_CARRY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |-> (psr_o[0] == $past(psr_i[0]))); // R7

endmodule

bind idx_abs_seq idx_abs_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .bus_kind (bus_kind),
    .acc_we   (acc_we),
    .acc_o    (acc_o),
    .psr_o    (psr_o),
    .psr_i    (psr_i)
);

// File: tb/idx_abs_seq_test.sv
// Bench: builds an expected per-cycle queue from the requirements and
// compares the design against it on every clock.
module idx_abs_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] PBASE = 16'h0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [1:0]  bus_kind;
    logic [7:0]  idx = 8'h00;
    logic [7:0]  acc_i = 8'h00;
    logic [7:0]  psr_i = 8'h00;
    logic        acc_we;
    logic [7:0]  acc_o;
    logic [7:0]  psr_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] prog [0:63];

    typedef struct {
        logic [15:0] addr;
        logic [1:0]  kind;
        logic        we;
        logic [7:0]  ra;
        logic [7:0]  rp;
        logic [7:0]  x;
        logic [7:0]  a;
        logic [7:0]  p;
    } exp_t;

    exp_t  q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    idx_abs_seq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .bus_kind  (bus_kind),
        .idx       (idx),
        .acc_i     (acc_i),
        .psr_i     (psr_i),
        .acc_we    (acc_we),
        .acc_o     (acc_o),
        .psr_o     (psr_o)
    );

    function automatic logic [7:0] memfn(input logic [15:0] a);
        if (a >= PBASE && a < PBASE + 16'd64) return prog[a - PBASE];
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    always_comb mem_rdata = memfn(mem_addr);

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // model state of external accumulator/status registers
    logic [15:0] m_pc;
    logic [7:0]  m_a, m_p;
    logic        pend_we;
    logic [7:0]  pend_a, pend_p;

    task automatic push(input logic [15:0] ad, input logic [1:0] k,
                        input logic [7:0] x, input string tag);
        exp_t e;
        e.addr = ad; e.kind = k; e.x = x; e.a = m_a; e.p = m_p;
        e.we = 1'b0; e.ra = 8'h00; e.rp = 8'h00;
        if (k == 2'd0) begin
            e.we = pend_we; e.ra = pend_a; e.rp = pend_p;
            pend_we = 1'b0;
        end
        q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic add_instr(input logic [7:0] opc, input logic [15:0] base,
                             input logic [7:0] x);
        logic [8:0]  lsum;
        logic [15:0] da;
        logic [7:0]  d, r, np;
        prog[m_pc - PBASE]       = opc;
        prog[m_pc + 16'd1 - PBASE] = base[7:0];
        prog[m_pc + 16'd2 - PBASE] = base[15:8];
        push(m_pc, 2'd0, x, "R8");
        push(m_pc + 16'd1, 2'd1, x, "R1");
        push(m_pc + 16'd2, 2'd1, x, "R1");
        m_pc = m_pc + 16'd3;
        lsum = {1'b0, base[7:0]} + {1'b0, x};
        if (lsum[8]) begin
            push({base[15:8], lsum[7:0]}, 2'd2, x, "R3");
            da = {base[15:8] + 8'd1, lsum[7:0]};
            push(da, 2'd3, x, (base[15:8] == 8'hFF) ? "R4" : "R3");
        end else begin
            da = {base[15:8], lsum[7:0]};
            push(da, 2'd3, x, "R2");
        end
        d = memfn(da);
        r = (opc == 8'h1D) ? (m_a | d) : d;
        np = m_p;
        np[1] = (r == 8'h00);
        np[7] = r[7];
        pend_we = 1'b1; pend_a = r; pend_p = np;
        m_a = r; m_p = np;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) prog[i] = 8'h00;
        m_pc = PBASE; m_a = 8'h33; m_p = 8'h25; pend_we = 1'b0;
        pend_a = 8'h00; pend_p = 8'h00;
        add_instr(8'hBD, 16'h1234, 8'h10);  // no carry, load
        add_instr(8'h1D, 16'h12F0, 8'h20);  // carry, OR
        add_instr(8'hBD, 16'hFFFF, 8'h01);  // wrap to 0x0000
        add_instr(8'hBD, 16'h0050, 8'h0A);  // reads 0x005A -> zero result
        m_p = m_p ^ 8'h7C;                  // other status bits change externally
        add_instr(8'h1D, 16'h3400, 8'hFF);  // no carry at 0x34FF
        add_instr(8'hA9, 16'h80FF, 8'hFF);  // non-OR code loads, carry
        add_instr(8'hBD, 16'h4000, 8'h00);  // zero index
        add_instr(8'h1D, 16'h0100, 8'h80);  // OR, negative result
        push(m_pc, 2'd0, 8'h00, "R5");      // trailing fetch carries last write-back

        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R9", "reset addr", mem_addr, 16'h0200);
        check("R9", "reset kind", {14'd0, bus_kind}, 16'd0);
        check("R9", "reset we", {15'd0, acc_we}, 16'd0);
        rst_n = 1'b1;
        while (q.size() > 0) begin
            exp_t e;
            string t;
            e = q.pop_front();
            t = tag_q.pop_front();
            idx = e.x; acc_i = e.a; psr_i = e.p;
            #1;
            check(t, "addr", mem_addr, e.addr);
            check("R8", "kind", {14'd0, bus_kind}, {14'd0, e.kind});
            check("R5", "we", {15'd0, acc_we}, {15'd0, e.we});
            if (e.we) begin
                check("R6", "acc", {8'd0, acc_o}, {8'd0, e.ra});
                check("R7", "psr", {8'd0, psr_o}, {8'd0, e.rp});
            end
            @(negedge clk);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule